// File: doc/BRIEF.md
# Register-Programmed GPIO Block with Sticky Level Interrupts

This block runs a bank of general-purpose pins from a small word-addressed register bus. Each pin is either a plain GPIO or is handed to an alternate on-chip peripheral. As a GPIO, a pin is an input or an output. Software drives output values through a data word. Reads of the same word return the pin states after a two-flop synchroniser.

Every pin has a programmable match level. A status bit latches whenever the synchronised pin value equals that level. The bit then holds until software clears it by writing zero. A per-pin enable word selects which status bits reach a single registered non-maskable interrupt line.

Bus reads are combinational from the address. Writes take effect at the clock edge on which `bus_en` and `bus_we` are both high.

Top module: `gpio_lvl_ctl`

## Requirements
- R1: After reset, the select, direction, level and NMI-enable words all read 0, `pad_oe` is 0 and `nmi_o` is 0.
- R2: The byte addresses are 0x00 for function select, 0x04 for direction, 0x08 for data, 0x0C for level, 0x10 for status and 0x14 for NMI enable. The select, direction, level and NMI-enable words read back the last value written to them.
- R3: A pin in GPIO mode (select bit 0) drives `pad_oe` high only when its direction bit is 1 (output). It then drives the value last written to the data word on `pad_out`.
- R4: A pin whose select bit is 1 takes its `pad_out` and `pad_oe` from `alt_out` and `alt_oe`.
- R5: A read of the data word returns `pad_in` delayed by two clock edges, from the synchroniser.
- R6: A status bit is set one edge after its synchronised pin value equals its level bit.
- R7: A status bit stays set after its pin stops matching.
- R8: Writing the status word clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R9: If a pin still matches in the cycle its status bit is cleared, the bit stays set.
- R10: `nmi_o` is a register holding the OR of status AND NMI enable from the previous edge.
- R11: Byte addresses 0x18 and 0x1C read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data (combinational) |
| pad_in | input | W | Pin values from the pads |
| pad_out | output | W | Values to drive on the pads |
| pad_oe | output | W | Pad output enables |
| alt_out | input | W | Alternate-function output values |
| alt_oe | input | W | Alternate-function output enables |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The hardest situation to set up from the ports is a status bit that is actually cleared. Right after reset, every pin is 0 and every level is 0, so every status bit re-sets on every cycle. The stimulus first programs all levels to 1 and holds the external pins at 0 long enough for the synchroniser to settle. Only then does it clear status, raise single pins and drop them again. This exposes stickiness, the per-bit write-zero clear and the set-over-clear case. The bench models the pads as a loopback, so pins configured as outputs read back their own driven value.

// File: rtl/gpio_lvl_ctl.sv
module gpio_lvl_ctl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_en,
  input  logic         bus_we,
  input  logic [4:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  output logic         nmi_o
);

  localparam logic [2:0] A_SEL = 3'd0, A_DIR = 3'd1, A_DAT = 3'd2,
                         A_LVL = 3'd3, A_STA = 3'd4, A_NMI = 3'd5;

  logic [W-1:0] sel_q, dir_q, dout_q, lvl_q, sta_q, nen_q;
  logic [W-1:0] sync1_q, sync2_q;
  logic [W-1:0] hit, sta_keep;
  logic [2:0]   widx;
  logic         wr;

  assign widx = bus_addr[4:2];
  assign wr   = bus_en && bus_we;
  assign hit  = ~(sync2_q ^ lvl_q);
  assign sta_keep = (wr && widx == A_STA) ? bus_wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      lvl_q  <= '0;
      nen_q  <= '0;
    end else if (wr) begin
      case (widx)
        A_SEL:   sel_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_DAT:   dout_q <= bus_wdata;
        A_LVL:   lvl_q  <= bus_wdata;
        A_NMI:   nen_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      nmi_o <= 1'b0;
    end else begin
      sta_q <= (sta_q & sta_keep) | hit;
      nmi_o <= |(sta_q & nen_q);
    end
  end

  always_comb begin
    case (widx)
      A_SEL:   bus_rdata = sel_q;
      A_DIR:   bus_rdata = dir_q;
      A_DAT:   bus_rdata = sync2_q;
      A_LVL:   bus_rdata = lvl_q;
      A_STA:   bus_rdata = sta_q;
      A_NMI:   bus_rdata = nen_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out = (sel_q & alt_out) | (~sel_q & dout_q);
  assign pad_oe  = (sel_q & alt_oe)  | (~sel_q & dir_q);

  AST_GPIO_IN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~sel_q & ~dir_q) == '0); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && widx == A_STA) |=> (sta_q & $past(sta_q)) == $past(sta_q)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sta_q & $past(hit)) == $past(hit)); // R9
  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past((sta_q & nen_q) != '0)); // R10
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sync1_q) |=> $stable(sync2_q) || sync2_q == $past(sync1_q)); // R5

endmodule

// File: tb/gpio_lvl_ctl_tb.sv
module gpio_lvl_ctl_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe, pad_in;
  logic [W-1:0] alt_out = '0, alt_oe = '0, ext = '0;
  logic         nmi_o;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [W-1:0] exp; string tag; } item_t;
  item_t sbq[$];
  event rd_ev;

  always #2 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_lvl_ctl #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .nmi_o(nmi_o));

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(rd_ev);
      if (sbq.size() != 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    #1 -> rd_ev;
    #0 bus_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    wait_cyc(3);
    @(negedge clk) rst_n = 1;
    #1;
    chk(pad_oe, '0, "R1 pad_oe");
    chk({31'd0, nmi_o}, '0, "R1 nmi");
    rd(5'h00, '0, "R1 sel");
    rd(5'h04, '0, "R1 dir");
    rd(5'h0C, '0, "R1 lvl");
    rd(5'h14, '0, "R1 nmien");
    wait_cyc(3);
    rd(5'h10, '1, "R6 status set by zero pins at zero level");
    wr(5'h0C, '1);
    wait_cyc(2);
    wr(5'h10, '0);
    rd(5'h10, '0, "R8 clear to zero");
    @(negedge clk) ext = 32'h3;
    wait_cyc(4);
    rd(5'h10, 32'h3, "R6 pins 0,1 match");
    @(negedge clk) ext = 32'h0;
    wait_cyc(4);
    rd(5'h10, 32'h3, "R7 sticky after mismatch");
    wr(5'h10, 32'h1);
    rd(5'h10, 32'h1, "R8 one keeps, zero clears");
    @(negedge clk) ext = 32'h4;
    wait_cyc(4);
    wr(5'h10, 32'h0);
    rd(5'h10, 32'h4, "R9 set wins over clear");
    chk({31'd0, nmi_o}, '0, "R10 masked");
    wr(5'h14, 32'h4);
    chk({31'd0, nmi_o}, '0, "R10 register latency");
    @(negedge clk);
    chk({31'd0, nmi_o}, 32'h1, "R10 nmi asserted");
    @(negedge clk) ext = 32'h0;
    wait_cyc(3);
    wr(5'h10, 32'h0);
    chk({31'd0, nmi_o}, 32'h1, "R10 nmi held one edge");
    @(negedge clk);
    chk({31'd0, nmi_o}, '0, "R10 nmi released");
    @(negedge clk) ext = 32'hA5A5_0000;
    rd(5'h08, 32'h0, "R5 old value after one edge");
    rd(5'h08, 32'hA5A5_0000, "R5 new value after two edges");
    wr(5'h04, 32'hFF);
    wr(5'h08, 32'h5A);
    #1;
    chk(pad_oe, 32'hFF, "R3 oe");
    chk(pad_out, 32'h5A, "R3 out");
    wait_cyc(2);
    rd(5'h08, 32'hA5A5_005A, "R3 loopback read");
    @(negedge clk) begin alt_out = 32'hC; alt_oe = 32'h3; end
    wr(5'h00, 32'h0F);
    #1;
    chk(pad_oe, 32'hF3, "R4 oe mux");
    chk(pad_out, 32'h5C, "R4 out mux");
    rd(5'h00, 32'h0F, "R2 sel");
    rd(5'h04, 32'hFF, "R2 dir");
    rd(5'h0C, '1, "R2 lvl");
    rd(5'h14, 32'h4, "R2 nmien");
    wr(5'h18, '1);
    wr(5'h1C, '1);
    rd(5'h18, '0, "R11 read 0x18");
    rd(5'h1C, '0, "R11 read 0x1C");
    rd(5'h00, 32'h0F, "R11 sel untouched");
    rd(5'h04, 32'hFF, "R11 dir untouched");
    rd(5'h14, 32'h4, "R11 nmien untouched");
    wait_cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule